// File: doc/BRIEF.md
# x86-64 Memory Operand Address Decoder

This block turns the addressing bytes of one memory operand into a decoded addressing mode and a computed effective address. It receives the ModR/M byte, the byte that would follow it as a SIB byte, the two register-extension bits from a REX prefix, a flag selecting 64-bit or 32-bit operation, and up to four raw displacement bytes. From these it decides whether the operand is a register or memory. For memory it reports the base register, the index register, the scale, the displacement size, whether the address is relative to the instruction pointer, and how many addressing bytes the operand uses.

It handles the irregular escape encodings. In 64-bit mode the short absolute-displacement form is reused for instruction-pointer-relative addressing. The SIB byte has its own codes for "no index" and "no base". Because of those codes, a plain RBP or R13 base must be written with a zero 8-bit displacement.

The effective address is computed from a flat vector of sixteen 64-bit register values and the address of the next instruction, both supplied by the surrounding pipeline. The result is registered, so it appears one clock after the operand is presented.

Top module: `ea_decoder_top`

## Requirements
- R1: With Mod (ModR/M bits 7:6) equal to 11 the operand is a register. out_mem is 0, out_has_base and out_has_index are 0, out_ea is 0 and out_len is 1.
- R2: Mod=01 adds a sign-extended 8-bit displacement taken from disp_raw[7:0], and out_disp_len is 1. Mod=10 adds the 32-bit disp_raw sign-extended to 64 bits, and out_disp_len is 4. Mod=00 adds no displacement, except in the escapes of R3, R4 and R7. Without a SIB byte, the base register number is {REX.B, ModR/M bits 2:0}.
- R3: In 64-bit mode, Mod=00 with R/M (bits 2:0) equal to 101 is instruction-pointer-relative. out_rip_rel is 1, there is no base and no index, out_disp_len is 4, and out_ea is next_ip plus the sign-extended disp32.
- R4: In 32-bit mode the same pattern is an absolute disp32. out_rip_rel is 0, there is no base, and out_ea is the sign-extended displacement truncated as in R11.
- R5: R/M=100 with Mod≠11 means a SIB byte is present. out_len counts it, and the base register number is {REX.B, SIB bits 2:0}.
- R6: The index number is {REX.X, SIB bits 5:3}. Only the value 0100 means no index, so R12 is a usable index. With an index, out_scale is SIB bits 7:6 and the index value is multiplied by 2^out_scale. Without an index, out_scale is 0 whatever the scale bits are.
- R7: In a SIB byte with Mod=00, base bits 101 mean no base register plus a disp32. REX.B has no effect on this decode.
- R8: Mod=01 with base low bits 101 selects RBP, or R13 when REX.B=1, with an 8-bit displacement. No operand has a base register whose low bits are 101 while having no displacement.
- R9: out_len = 1 + (1 if a SIB byte is present) + out_disp_len. It lies between 1 and 6.
- R10: out_ea = base value + (index value << scale) + sign-extended displacement, modulo 2^64.
- R11: With long_mode=0, rex_b and rex_x are ignored (register numbers stay 0 to 7), and out_ea is the 32-bit sum zero-extended.
- R12: out_vld is 0 after reset. Each output reflects the inputs sampled at the previous rising clock edge on which in_vld was 1, and out_vld equals in_vld delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand bytes on the inputs are valid |
| modrm | input | 8 | ModR/M byte |
| sib | input | 8 | Byte following ModR/M, used when a SIB is present |
| rex_b | input | 1 | Base/R-M register extension bit |
| rex_x | input | 1 | Index register extension bit |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| disp_raw | input | 32 | Displacement bytes, little-endian, disp8 in bits 7:0 |
| regs_flat | input | NUM_GPR*ADDR_W | Register values, register n in bits n*ADDR_W upward |
| next_ip | input | ADDR_W | Address of the next instruction |
| out_vld | output | 1 | Decoded result valid |
| out_mem | output | 1 | Operand is a memory reference |
| out_has_base | output | 1 | A base register is used |
| out_base | output | 4 | Base register number |
| out_has_index | output | 1 | An index register is used |
| out_index | output | 4 | Index register number |
| out_scale | output | 2 | log2 of the index scale |
| out_disp_len | output | 3 | Displacement bytes: 0, 1 or 4 |
| out_rip_rel | output | 1 | Address is relative to next_ip |
| out_len | output | 3 | Addressing bytes consumed |
| out_ea | output | ADDR_W | Effective address |

## Verification
The bench builds the block with its defaults: 64-bit addresses and sixteen registers. These are the only values that match the encoding, and they make the REX bits reach R8 to R15. In each mode it sweeps every ModR/M value against every SIB value, with REX bits and displacements varied. This brings every escape into reach, including the pair that combines the SIB no-index and no-base codes. A behavioural model compares every decoded field and the address on each clock. The register file is loaded with values that have high bits set, so a wrong 32-bit truncation or a missing sign extension changes the address.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int REG_NUM_W  = 4;
    localparam int DISP_RAW_W = 32;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_8    = 2'd1,
        DSZ_32   = 2'd2
    } dsz_e;

    typedef struct packed {
        logic                 is_mem;
        logic                 has_sib;
        logic                 has_base;
        logic [REG_NUM_W-1:0] base;
        logic                 has_index;
        logic [REG_NUM_W-1:0] index;
        logic [1:0]           scale_log;
        dsz_e                 dsz;
        logic                 rip_rel;
    } ea_mode_t;

    function automatic logic [2:0] dsz_bytes(input dsz_e d);
        case (d)
            DSZ_8:   return 3'd1;
            DSZ_32:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic dsz_e dsz_from_mod(input logic [1:0] md);
        case (md)
            2'b01:   return DSZ_8;
            2'b10:   return DSZ_32;
            default: return DSZ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [7:0] modrm,
    input  logic [7:0] sib,
    input  logic       rex_b,
    input  logic       rex_x,
    input  logic       long_mode,
    output ea_mode_t   mode,
    output logic [2:0] len
);

    localparam logic [2:0] ESC_SIB    = 3'b100;
    localparam logic [2:0] ESC_NOBASE = 3'b101;
    localparam logic [3:0] NO_INDEX   = 4'b0100;

    logic [1:0] md;
    logic [2:0] rm;
    logic       ext_b;
    logic       ext_x;
    logic [3:0] idx_code;

    always_comb begin
        md       = modrm[7:6];
        rm       = modrm[2:0];
        ext_b    = long_mode & rex_b;
        ext_x    = long_mode & rex_x;
        idx_code = {ext_x, sib[5:3]};
        mode     = '0;
        mode.dsz = DSZ_NONE;
        if (md != 2'b11) begin
            mode.is_mem = 1'b1;
            mode.dsz    = dsz_from_mod(md);
            if (rm == ESC_SIB) begin
                mode.has_sib = 1'b1;
                if (idx_code != NO_INDEX) begin
                    mode.has_index = 1'b1;
                    mode.index     = idx_code;
                    mode.scale_log = sib[7:6];
                end
                if (md == 2'b00 && sib[2:0] == ESC_NOBASE) begin
                    mode.dsz = DSZ_32;
                end else begin
                    mode.has_base = 1'b1;
                    mode.base     = {ext_b, sib[2:0]};
                end
            end else if (md == 2'b00 && rm == ESC_NOBASE) begin
                mode.dsz     = DSZ_32;
                mode.rip_rel = long_mode;
            end else begin
                mode.has_base = 1'b1;
                mode.base     = {ext_b, rm};
            end
        end
        len = 3'd1 + {2'b00, mode.has_sib} + dsz_bytes(mode.dsz);
    end

endmodule

// File: rtl/ea_disp_extend.sv
module ea_disp_extend
    import ea_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  dsz_e                  dsz,
    input  logic [DISP_RAW_W-1:0] raw,
    output logic [ADDR_W-1:0]     disp
);

    always_comb begin
        case (dsz)
            DSZ_8:   disp = ADDR_W'($signed(raw[7:0]));
            DSZ_32:  disp = ADDR_W'($signed(raw));
            default: disp = '0;
        endcase
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int NUM_GPR = 16
) (
    input  ea_mode_t                  mode,
    input  logic [ADDR_W-1:0]         disp,
    input  logic [NUM_GPR*ADDR_W-1:0] regs_flat,
    input  logic [ADDR_W-1:0]         next_ip,
    input  logic                      long_mode,
    output logic [ADDR_W-1:0]         ea
);

    logic [ADDR_W-1:0] gpr [NUM_GPR];
    logic [ADDR_W-1:0] base_val;
    logic [ADDR_W-1:0] index_val;
    logic [ADDR_W-1:0] ip_val;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] narrow_mask;

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
        assign gpr[g] = regs_flat[g*ADDR_W +: ADDR_W];
    end

    if (ADDR_W > 32) begin : g_mask_wide
        assign narrow_mask = {{(ADDR_W-32){1'b0}}, {32{1'b1}}};
    end else begin : g_mask_narrow
        assign narrow_mask = '1;
    end

    always_comb begin
        base_val  = mode.has_base  ? gpr[mode.base] : '0;
        index_val = mode.has_index ? (gpr[mode.index] << mode.scale_log) : '0;
        ip_val    = mode.rip_rel   ? next_ip : '0;
        sum       = base_val + index_val + ip_val + disp;
        if (!mode.is_mem)
            ea = '0;
        else if (!long_mode)
            ea = sum & narrow_mask;
        else
            ea = sum;
    end

endmodule

// File: rtl/ea_decoder_top.sv
module ea_decoder_top
    import ea_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int NUM_GPR = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic [7:0]                modrm,
    input  logic [7:0]                sib,
    input  logic                      rex_b,
    input  logic                      rex_x,
    input  logic                      long_mode,
    input  logic [31:0]               disp_raw,
    input  logic [NUM_GPR*ADDR_W-1:0] regs_flat,
    input  logic [ADDR_W-1:0]         next_ip,
    output logic                      out_vld,
    output logic                      out_mem,
    output logic                      out_has_base,
    output logic [3:0]                out_base,
    output logic                      out_has_index,
    output logic [3:0]                out_index,
    output logic [1:0]                out_scale,
    output logic [2:0]                out_disp_len,
    output logic                      out_rip_rel,
    output logic [2:0]                out_len,
    output logic [ADDR_W-1:0]         out_ea
);

    ea_mode_t          mode;
    logic [2:0]        len;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] ea;

    ea_mode_decode i_decode (
        .modrm     (modrm),
        .sib       (sib),
        .rex_b     (rex_b),
        .rex_x     (rex_x),
        .long_mode (long_mode),
        .mode      (mode),
        .len       (len)
    );

    ea_disp_extend #(.ADDR_W(ADDR_W)) i_disp (
        .dsz  (mode.dsz),
        .raw  (disp_raw),
        .disp (disp)
    );

    ea_addr_calc #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) i_calc (
        .mode      (mode),
        .disp      (disp),
        .regs_flat (regs_flat),
        .next_ip   (next_ip),
        .long_mode (long_mode),
        .ea        (ea)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld       <= 1'b0;
            out_mem       <= 1'b0;
            out_has_base  <= 1'b0;
            out_base      <= '0;
            out_has_index <= 1'b0;
            out_index     <= '0;
            out_scale     <= '0;
            out_disp_len  <= '0;
            out_rip_rel   <= 1'b0;
            out_len       <= '0;
            out_ea        <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_mem       <= mode.is_mem;
                out_has_base  <= mode.has_base;
                out_base      <= mode.base;
                out_has_index <= mode.has_index;
                out_index     <= mode.index;
                out_scale     <= mode.scale_log;
                out_disp_len  <= dsz_bytes(mode.dsz);
                out_rip_rel   <= mode.rip_rel;
                out_len       <= len;
                out_ea        <= ea;
            end
        end
    end

    AST_REG_DIRECT_NO_EA: assert property (@(posedge clk) disable iff (rst)
        out_vld && !out_mem |-> out_ea == '0 && !out_has_base && !out_has_index && out_len == 3'd1); // R1
    AST_RIP_ALONE: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_rip_rel |-> !out_has_base && !out_has_index && out_disp_len == 3'd4); // R3
    AST_RIP_ONLY_LONG: assert property (@(posedge clk) disable iff (rst)
        in_vld && !long_mode |=> !out_rip_rel); // R4
    AST_ABS_NEEDS_DISP32: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_mem && !out_has_base && !out_rip_rel |-> out_disp_len == 3'd4); // R7
    AST_NO_SCALE_WITHOUT_INDEX: assert property (@(posedge clk) disable iff (rst)
        out_vld && !out_has_index |-> out_scale == 2'd0); // R6
    AST_BP_NEEDS_DISP: assert property (@(posedge clk) disable iff (rst)
        out_vld && out_has_base && out_disp_len == 3'd0 |-> out_base[2:0] != 3'b101); // R8
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_len >= 3'd1 && out_len <= 3'd6); // R9
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld); // R12
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld); // R12

endmodule

// File: tb/test_ea_decoder_top.sv
module test_ea_decoder_top;

    localparam int AW   = 64;
    localparam int NREG = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_vld = 1'b0;
    logic [7:0]        modrm = '0;
    logic [7:0]        sib = '0;
    logic              rex_b = 1'b0;
    logic              rex_x = 1'b0;
    logic              long_mode = 1'b1;
    logic [31:0]       disp_raw = '0;
    logic [NREG*AW-1:0] regs_flat;
    logic [AW-1:0]     next_ip = '0;
    logic              out_vld, out_mem, out_has_base, out_has_index, out_rip_rel;
    logic [3:0]        out_base, out_index;
    logic [1:0]        out_scale;
    logic [2:0]        out_disp_len, out_len;
    logic [AW-1:0]     out_ea;

    always #2.5 clk = ~clk;

    ea_decoder_top i_ea_decoder_top (
        .clk(clk), .rst(rst), .in_vld(in_vld), .modrm(modrm), .sib(sib),
        .rex_b(rex_b), .rex_x(rex_x), .long_mode(long_mode), .disp_raw(disp_raw),
        .regs_flat(regs_flat), .next_ip(next_ip), .out_vld(out_vld), .out_mem(out_mem),
        .out_has_base(out_has_base), .out_base(out_base), .out_has_index(out_has_index),
        .out_index(out_index), .out_scale(out_scale), .out_disp_len(out_disp_len),
        .out_rip_rel(out_rip_rel), .out_len(out_len), .out_ea(out_ea)
    );

    typedef struct {
        bit        vld;
        bit        mem;
        bit        hb;
        bit [3:0]  b;
        bit        hi;
        bit [3:0]  ix;
        bit [1:0]  sc;
        bit [2:0]  dl;
        bit        rip;
        bit [2:0]  len;
        bit [63:0] ea;
        string     tb;
        string     te;
    } exp_t;

    exp_t      exp_q[$];
    bit [63:0] rv [NREG];
    int        n_checks = 0;
    int        n_fail   = 0;
    int        n_cycles = 0;

    initial begin
        for (int i = 0; i < NREG; i++) begin
            rv[i] = 64'h8765_4321_0000_0000 ^ (64'(i + 1) * 64'h0000_0003_1357_9BDF);
            regs_flat[i*AW +: AW] = rv[i];
        end
    end

    task automatic chk(input string tag, input string what, input bit [63:0] act, input bit [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t ref_model(input bit [7:0] m, input bit [7:0] s, input bit rb,
                                       input bit rx, input bit lm, input bit [31:0] d,
                                       input bit [63:0] nip);
        exp_t      e;
        int        md, r, sbase, dl, iv;
        bit        bx, xx, sibp;
        bit [63:0] dv, sum;
        e = '{vld: 1, tb: "R2", te: "R10", default: 0};
        md = int'(m[7:6]); r = int'(m[2:0]);
        bx = lm ? rb : 1'b0; xx = lm ? rx : 1'b0;
        if (md == 3) begin
            e.len = 1; e.tb = "R1"; e.te = "R1";
            return e;
        end
        e.mem = 1;
        dl = (md == 1) ? 1 : (md == 2) ? 4 : 0;
        sibp = (r == 4);
        if (sibp) begin
            iv = xx * 8 + int'(s[5:3]);
            if (iv != 4) begin e.hi = 1; e.ix = 4'(iv); e.sc = s[7:6]; end
            sbase = int'(s[2:0]);
            if (md == 0 && sbase == 5) begin
                dl = 4; e.tb = "R7";
            end else begin
                e.hb = 1; e.b = 4'(bx * 8 + sbase);
                e.tb = (md == 1 && sbase == 5) ? "R8" : "R5";
            end
        end else if (md == 0 && r == 5) begin
            dl = 4; e.rip = lm; e.tb = lm ? "R3" : "R4";
        end else begin
            e.hb = 1; e.b = 4'(bx * 8 + r);
            e.tb = (md == 1 && r == 5) ? "R8" : "R2";
        end
        e.dl  = 3'(dl);
        e.len = 3'(1 + (sibp ? 1 : 0) + dl);
        if (dl == 1) dv = {{56{d[7]}}, d[7:0]};
        else if (dl == 4) dv = {{32{d[31]}}, d};
        else dv = 0;
        sum = dv;
        if (e.hb)  sum = sum + rv[e.b];
        if (e.hi)  sum = sum + (rv[e.ix] * (64'd1 << e.sc));
        if (e.rip) sum = sum + nip;
        if (!lm) begin sum = {32'd0, sum[31:0]}; e.te = "R11"; end
        else if (e.rip) e.te = "R3";
        e.ea = sum;
        return e;
    endfunction

    task automatic compare(input exp_t e);
        chk("R12", "out_vld", 64'(out_vld), 64'(e.vld));
        if (!e.vld) return;
        chk(e.mem ? "R2" : "R1", "out_mem", 64'(out_mem), 64'(e.mem));
        chk(e.tb, "out_has_base", 64'(out_has_base), 64'(e.hb));
        if (e.hb) chk(e.tb, "out_base", 64'(out_base), 64'(e.b));
        chk("R6", "out_has_index", 64'(out_has_index), 64'(e.hi));
        if (e.hi) chk("R6", "out_index", 64'(out_index), 64'(e.ix));
        chk("R6", "out_scale", 64'(out_scale), 64'(e.sc));
        chk(e.tb, "out_disp_len", 64'(out_disp_len), 64'(e.dl));
        chk(e.tb, "out_rip_rel", 64'(out_rip_rel), 64'(e.rip));
        chk("R9", "out_len", 64'(out_len), 64'(e.len));
        chk(e.te, "out_ea", out_ea, e.ea);
    endtask

    task automatic step(input bit v, input bit [7:0] m, input bit [7:0] s, input bit rb,
                        input bit rx, input bit lm, input bit [31:0] d);
        exp_t e;
        @(negedge clk);
        if (exp_q.size() > 0) compare(exp_q.pop_front());
        in_vld = v; modrm = m; sib = s; rex_b = rb; rex_x = rx; long_mode = lm; disp_raw = d;
        next_ip = 64'h0000_7FFF_FFFF_F000 + 64'(n_cycles);
        if (v) e = ref_model(m, s, rb, rx, lm, d, next_ip);
        else e = '{vld: 0, tb: "R12", te: "R12", default: 0};
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 190000) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual %0d cycles expected fewer", n_cycles);
            finish_run();
        end
    end

    initial begin
        bit [31:0] rnd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "out_vld in reset", 64'(out_vld), 64'd0);
        rst = 1'b0;
        // R8: [R13] via disp8=0, R6: R12 usable as index
        step(1, 8'h45, 8'h00, 1, 0, 1, 32'h0);
        step(1, 8'h04, 8'h60, 0, 1, 1, 32'h0);
        step(1, 8'h04, 8'hE5, 1, 0, 1, 32'h8000_0000); // R7 no base, R6 no index
        step(0, 8'h00, 8'h00, 0, 0, 1, 32'h0);         // R12 idle
        step(1, 8'h05, 8'h00, 0, 0, 1, 32'hFFFF_FFF0); // R3 negative offset
        step(1, 8'h05, 8'h00, 1, 1, 0, 32'h1234_5678); // R4 and R11
        step(1, 8'h44, 8'h5D, 1, 1, 1, 32'h0000_0080); // R8 SIB base 101 with disp8
        for (int lm = 1; lm >= 0; lm--) begin
            for (int m = 0; m < 256; m++) begin
                for (int s = 0; s < 256; s++) begin
                    rnd = $urandom;
                    step(1, 8'(m), 8'(s), rnd[0], rnd[1], 1'(lm), $urandom);
                end
            end
        end
        step(0, 8'h00, 8'h00, 0, 0, 1, 32'h0);
        step(0, 8'h00, 8'h00, 0, 0, 1, 32'h0);
        finish_run();
    end

endmodule